// File: doc/BRIEF.md
# Transmitter Loop Delay Meter and Secondary Sample Strobe

This block measures, in system clock cycles, how long a bit that the node drives onto the transmit line takes to come back on the receive line. The measurement is taken once per CAN FD frame, on the falling (recessive-to-dominant) transmit edge at the boundary between the FD format bit and the reserved bit that follows it. The bit timing logic marks that edge with a strobe. The count includes the block's own receive synchroniser latency of two cycles, so the value is two higher than the wire delay. The value saturates and is held until the next measurement.

The measured delay, together with a configured offset, places a secondary sample point within each data-phase bit. The position is counted in system clocks from the bit start. A per-bit counter emits a one-cycle strobe at that position, and the bit error checker of a transmitter uses that strobe to compare its own bits. A mode input selects one of three position sources: the offset alone, the offset plus the measured delay, or no secondary point at all. In the last case, the regular data-phase sample pulse is forwarded to the output instead.

Top module: `loop_delay_ssp`

## Requirements
- R1: After reset the delay output is 0 and the strobe output is low.
- R2: The delay output equals the true transmit-to-receive delay D plus 2. D counts clock edges from the edge that samples the measure strobe with tx low to the edge that first samples rx low. The new value appears after the edge that is D+2 edges past the start edge.
- R3: The delay output saturates at 127. Longer delays read 127.
- R4: The delay output keeps its previous value until a measurement completes.
- R5: Mode code 0 (offset only) places the position at the offset value, 0 to 255. The per-bit count is 0 at the edge that samples bit_start and rises by one per edge. The strobe is high for the single cycle after the edge at which the count equals the position.
- R6: Mode code 1 places the position at the offset plus the current delay output.
- R7: In mode code 1 the sum is formed at 9 bits and clamped to 255, so it never wraps to a small value.
- R8: Mode codes 2 and 3 disable the secondary point. The strobe then follows the regular sample input one cycle later.
- R9: The strobe fires at most once per bit. It does not fire in a bit that ends (the next bit_start) before the position is reached.
- R10: No strobe is produced while data_phase is low.
- R11: When a measurement completes at the same edge where the count reaches the position, the position in force is the one built from the delay value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_bit_i | input | 1 | Transmit bit stream (0 = dominant) |
| rx_bit_i | input | 1 | Receive bit stream, asynchronous (0 = dominant) |
| meas_edge_i | input | 1 | Marks the cycle of the measured falling transmit edge |
| bit_start_i | input | 1 | One-cycle pulse at the start of each bit |
| data_phase_i | input | 1 | High during the data bit-rate phase |
| samp_pt_i | input | 1 | Regular data-phase sample point pulse |
| ssp_mode_i | input | 2 | Position source: 0 offset, 1 offset+delay, 2/3 disabled |
| ssp_offset_i | input | 8 | Secondary sample offset in clocks |
| delay_o | output | 7 | Measured loop delay in clocks |
| ssp_o | output | 1 | Secondary sample strobe |

## Verification
Two functions can act at the same clock edge: a delay measurement finishing, and the per-bit counter reaching a position that depends on that delay. The bench starts a bit and a measurement at the same edge. It picks the loop delay so that the measurement completes exactly at the edge where the old offset-plus-delay position is reached. It then checks that the strobe appears only at the old position and that the delay output carries the new value afterwards.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int DLY_W  = 7;
    localparam int POS_W  = 8;
    localparam int SYNC_N = 2;

    typedef enum logic [1:0] {
        SRC_OFFSET  = 2'b00,
        SRC_OFS_DLY = 2'b01,
        SRC_NONE_A  = 2'b10,
        SRC_NONE_B  = 2'b11
    } ssp_src_e;
endpackage

// File: rtl/dly_meas.sv
module dly_meas #(
    parameter int DLY_W  = 7,
    parameter int SYNC_N = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tx_bit_i,
    input  logic             rx_bit_i,
    input  logic             meas_edge_i,
    output logic [DLY_W-1:0] dly_o,
    output logic             done_o
);
    localparam logic [DLY_W-1:0] CNT_MAX = '1;
    localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

    typedef struct packed {
        logic              run;
        logic [DLY_W-1:0]  cnt;
        logic [DLY_W-1:0]  dly;
        logic [SYNC_N-1:0] sync;
    } meas_t;

    meas_t st_d, st_q;
    logic  rx_s;
    logic  start;

    assign rx_s  = st_q.sync[SYNC_N-1];
    assign start = meas_edge_i && !tx_bit_i;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_N-2:0], rx_bit_i};
        done_o    = 1'b0;
        if (start) begin
            st_d.run = 1'b1;
            st_d.cnt = CNT_ONE;
        end else if (st_q.run) begin
            if (!rx_s) begin
                st_d.run = 1'b0;
                st_d.dly = st_q.cnt;
                done_o   = 1'b1;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{run: 1'b0, cnt: '0, dly: '0, sync: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign dly_o = st_q.dly;
endmodule

// File: rtl/ssp_pos.sv
module ssp_pos
    import ssp_pkg::*;
#(
    parameter int DLY_W = 7,
    parameter int POS_W = 8
) (
    input  logic [1:0]       mode_i,
    input  logic [POS_W-1:0] offset_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic [POS_W-1:0] pos_o,
    output logic             en_o
);
    localparam int SUM_W = POS_W + 1;

    ssp_src_e         src;
    logic [SUM_W-1:0] sum;

    always_comb begin
        src = ssp_src_e'(mode_i);
        sum = {1'b0, offset_i};
        if (src == SRC_OFS_DLY) begin
            sum = sum + SUM_W'(dly_i);
        end
        pos_o = sum[POS_W] ? {POS_W{1'b1}} : sum[POS_W-1:0];
        en_o  = (src == SRC_OFFSET) || (src == SRC_OFS_DLY);
    end
endmodule

// File: rtl/ssp_strobe.sv
module ssp_strobe #(
    parameter int POS_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bit_start_i,
    input  logic             data_phase_i,
    input  logic             samp_pt_i,
    input  logic             en_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             ssp_o
);
    localparam logic [POS_W-1:0] CNT_MAX = '1;
    localparam logic [POS_W-1:0] CNT_ONE = POS_W'(1);

    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic             fired;
        logic             ssp;
    } stb_t;

    stb_t             st_d, st_q;
    logic [POS_W-1:0] eff;
    logic             fired_eff;
    logic             hit;

    always_comb begin
        st_d      = st_q;
        eff       = bit_start_i ? '0 : st_q.cnt;
        fired_eff = bit_start_i ? 1'b0 : st_q.fired;
        hit       = data_phase_i && en_i && (eff == pos_i) && !fired_eff;
        st_d.cnt  = (eff == CNT_MAX) ? CNT_MAX : eff + CNT_ONE;
        st_d.fired = fired_eff || hit;
        st_d.ssp  = en_i ? hit : (data_phase_i && samp_pt_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ssp_o = st_q.ssp;
endmodule

// File: rtl/loop_delay_ssp.sv
module loop_delay_ssp
    import ssp_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tx_bit_i,
    input  logic             rx_bit_i,
    input  logic             meas_edge_i,
    input  logic             bit_start_i,
    input  logic             data_phase_i,
    input  logic             samp_pt_i,
    input  logic [1:0]       ssp_mode_i,
    input  logic [POS_W-1:0] ssp_offset_i,
    output logic [DLY_W-1:0] delay_o,
    output logic             ssp_o
);
    logic             meas_done;
    logic [POS_W-1:0] pos;
    logic             pos_en;

    dly_meas #(.DLY_W(DLY_W), .SYNC_N(SYNC_N)) u_meas (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tx_bit_i   (tx_bit_i),
        .rx_bit_i   (rx_bit_i),
        .meas_edge_i(meas_edge_i),
        .dly_o      (delay_o),
        .done_o     (meas_done)
    );

    ssp_pos #(.DLY_W(DLY_W), .POS_W(POS_W)) u_pos (
        .mode_i  (ssp_mode_i),
        .offset_i(ssp_offset_i),
        .dly_i   (delay_o),
        .pos_o   (pos),
        .en_o    (pos_en)
    );

    ssp_strobe #(.POS_W(POS_W)) u_stb (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bit_start_i (bit_start_i),
        .data_phase_i(data_phase_i),
        .samp_pt_i   (samp_pt_i),
        .en_i        (pos_en),
        .pos_i       (pos),
        .ssp_o       (ssp_o)
    );
endmodule

// File: rtl/loop_delay_ssp_chk.sv
module loop_delay_ssp_chk #(
    parameter int DLY_W = 7
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ssp_o,
    input logic [1:0]       ssp_mode_i,
    input logic             bit_start_i,
    input logic             data_phase_i,
    input logic             samp_pt_i,
    input logic [DLY_W-1:0] delay_o,
    input logic             meas_done
);
    p_dp_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ssp_o |-> $past(data_phase_i));

    p_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ssp_o && !ssp_mode_i[1] && !bit_start_i) |=> (ssp_mode_i[1] || !ssp_o));

    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(meas_done) |-> $stable(delay_o));

    p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ssp_mode_i[1] && data_phase_i && samp_pt_i) |=> ssp_o);
endmodule

bind loop_delay_ssp loop_delay_ssp_chk #(.DLY_W(ssp_pkg::DLY_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ssp_o       (ssp_o),
    .ssp_mode_i  (ssp_mode_i),
    .bit_start_i (bit_start_i),
    .data_phase_i(data_phase_i),
    .samp_pt_i   (samp_pt_i),
    .delay_o     (delay_o),
    .meas_done   (meas_done)
);

// File: tb/loop_delay_ssp_bench.sv
module loop_delay_ssp_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx = 1'b1, rx = 1'b1, meas = 1'b0;
    logic       bstart = 1'b0, dphase = 1'b0, samp = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [7:0] offset = 8'd0;
    logic [6:0] delay;
    logic       ssp;

    int checks = 0;
    int errors = 0;
    int cur_dly = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    loop_delay_ssp u_loop_delay_ssp (
        .clk_i(clk), .rst_ni(rst_n), .tx_bit_i(tx), .rx_bit_i(rx),
        .meas_edge_i(meas), .bit_start_i(bstart), .data_phase_i(dphase),
        .samp_pt_i(samp), .ssp_mode_i(mode), .ssp_offset_i(offset),
        .delay_o(delay), .ssp_o(ssp)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] off;
        logic [9:0] len;
        logic [9:0] samp_at;
        logic       dp;
    } vec_t;

    // mode, offset, bit length, regular sample edge, data phase
    localparam vec_t VEC [9] = '{
        '{2'd0, 8'd10,  10'd20,  10'd999, 1'b1},
        '{2'd0, 8'd0,   10'd8,   10'd999, 1'b1},
        '{2'd1, 8'd10,  10'd40,  10'd999, 1'b1},
        '{2'd1, 8'd250, 10'd300, 10'd999, 1'b1},
        '{2'd1, 8'd250, 10'd100, 10'd999, 1'b1},
        '{2'd0, 8'd40,  10'd30,  10'd999, 1'b1},
        '{2'd0, 8'd255, 10'd300, 10'd999, 1'b1},
        '{2'd2, 8'd3,   10'd20,  10'd7,   1'b1},
        '{2'd0, 8'd5,   10'd20,  10'd999, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int d);
        int exp_v;
        @(negedge clk);
        tx = 1'b0; meas = 1'b1;
        if (d == 0) rx = 1'b0;
        for (int j = 0; j <= d + 2; j++) begin
            @(posedge clk);
            @(negedge clk);
            meas = 1'b0;
            if (j + 1 == d) rx = 1'b0;
            if (j == d + 1) check(delay == 7'(cur_dly), "R4 hold before completion", delay, cur_dly);
        end
        exp_v = (d + 2 > 127) ? 127 : d + 2;
        check(delay == 7'(exp_v), (d + 2 > 127) ? "R3 saturation" : "R2 delay plus two", delay, exp_v);
        cur_dly = exp_v;
        tx = 1'b1; rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_bit(input vec_t v);
        int n = 0, first = -1, exp_at, exp_n;
        if (v.mode[1]) exp_at = int'(v.samp_at);
        else begin
            exp_at = int'(v.off) + ((v.mode == 2'd1) ? cur_dly : 0);
            if (exp_at > 255) exp_at = 255;
        end
        exp_n = (v.dp && exp_at < int'(v.len)) ? 1 : 0;
        @(negedge clk);
        mode = v.mode; offset = v.off; dphase = v.dp;
        bstart = 1'b1; samp = (v.samp_at == 10'd0);
        for (int k = 0; k < int'(v.len); k++) begin
            @(posedge clk);
            @(negedge clk);
            bstart = 1'b0;
            samp = (10'(k + 1) == v.samp_at);
            if (ssp) begin
                n++;
                if (first < 0) first = k;
            end
        end
        samp = 1'b0;
        check(n == exp_n, "R5 R6 R7 R8 R9 R10 strobe count", n, exp_n);
        if (exp_n == 1) check(first == exp_at, "R5 R6 R7 R8 strobe position", first, exp_at);
    endtask

    initial begin
        int n, first;
        #12;
        check(delay == 7'd0, "R1 reset delay", delay, 0);
        check(ssp == 1'b0, "R1 reset strobe", ssp, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        measure(11);
        measure(0);
        measure(200);
        measure(11);

        foreach (VEC[i]) run_bit(VEC[i]);

        // R11: measurement completes at the edge where the old position is reached
        n = 0; first = -1;
        @(negedge clk);
        mode = 2'd1; offset = 8'd5; dphase = 1'b1;
        bstart = 1'b1; tx = 1'b0; meas = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(posedge clk);
            @(negedge clk);
            bstart = 1'b0; meas = 1'b0;
            if (k == 15) rx = 1'b0;
            if (ssp) begin
                n++;
                if (first < 0) first = k;
            end
        end
        tx = 1'b1; rx = 1'b1;
        check(n == 1 && first == 18, "R11 old position used", first, 18);
        check(delay == 7'd18, "R11 new delay stored", delay, 18);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule